// File: doc/BRIEF.md
# Divider Setting Configuration Port

This block keeps the divide settings of a clock synthesizer: a 9-bit feedback divide value M, a 2-bit output divide value N, and a 3-bit test-select code T. Two paths can load them. A mode input chooses which path is active.

While the mode input is low, the parallel path is active. M and N track a set of parallel pins, and T is cleared to zero, so the test output stays quiet. While the mode input is high, the serial path is active. Each rising edge of a serial clock shifts one data bit into a 14-bit frame register. A falling edge of a separate load strobe then copies the frame into the active M, N and T values.

All control and data inputs are brought into the system clock domain through synchronizer stages. Edges are detected there, so the serial clock and the strobe can be slow, unrelated signals driven from a board-level controller.

Top module: `divcfg_port`

## Requirements
- R1: After reset, `m_val`, `n_val`, `t_val` and `shift_out` are all zero.
- R2: While `ser_mode` is low, `m_val` and `n_val` follow `par_m` and `par_n` after the synchronizer latency.
- R3: While `ser_mode` is low, `t_val` is 0, even if a nonzero value was committed earlier.
- R4: While `ser_mode` is high, each rising edge of `ser_clk` shifts `ser_data` into the frame register. `shift_out` is the register end that holds the oldest bit, so after 14 shifts it shows the first bit sent.
- R5: The frame is 14 bits. The first three bits sent form T, the next two form N, and the last nine form M. Each field is sent most significant bit first.
- R6: A falling edge of `ser_load` while `ser_mode` is high commits the frame register to `t_val`, `n_val` and `m_val`. A rising edge of `ser_load` commits nothing.
- R7: While `ser_mode` is high and no commit occurs, the three outputs hold their values. This holds through further shifting and through changes on the parallel pins.
- R8: A `ser_load` strobe while `ser_mode` is low has no effect. The outputs keep following the parallel pins, and T stays 0.
- R9: When `ser_mode` rises, `m_val` and `n_val` keep the last parallel values until a serial commit.
- R10: While `ser_mode` is low, `ser_clk` edges do not shift the register. Its contents survive a parallel phase and can be committed afterwards.
- R11: If more than 14 bits are shifted before a commit, only the last 14 bits take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_mode | input | 1 | Low: parallel path active and T cleared; high: serial path active |
| ser_clk | input | 1 | Serial shift clock; sampled, rising edge shifts |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Commit strobe; falling edge commits |
| par_m | input | 9 | Parallel M value |
| par_n | input | 2 | Parallel N value |
| m_val | output | 9 | Active M divide value |
| n_val | output | 2 | Active N divide value |
| t_val | output | 3 | Active test-select code |
| shift_out | output | 1 | Oldest bit of the frame register |

## Verification
The bench rejects a design that commits on the rising strobe edge, because it checks the held values between the two strobe edges. It sends a frame with T=110 and N=11 and compares the result field by field, so a swapped or reversed field shows up as a wrong `t_val` or `m_val`. It pulses the strobe and the serial clock during the parallel phase, which catches any design that leaks a commit or a shift there. A final commit after that phase must reproduce the earlier frame exactly. It also sends 16 bits before one commit, so a design that counts bits instead of keeping the last 14 produces different field values.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;

    // Default field widths of the divider settings.
    localparam int DEF_M_W = 9;
    localparam int DEF_N_W = 2;
    localparam int DEF_T_W = 3;

    // Edge events of a synchronized level.
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[0] <= '0;
                else        chain_q[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= '0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/divcfg_edge.sv
module divcfg_edge
    import divcfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     lvl,
    output edge_ev_t ev
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d  = lvl;
        ev.rise = lvl & ~prev_q;
        ev.fall = ~lvl & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/divcfg_port.sv
module divcfg_port
    import divcfg_pkg::*;
#(
    parameter int M_W         = DEF_M_W,
    parameter int N_W         = DEF_N_W,
    parameter int T_W         = DEF_T_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_mode,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_load,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    output logic [M_W-1:0] m_val,
    output logic [N_W-1:0] n_val,
    output logic [T_W-1:0] t_val,
    output logic           shift_out
);

    localparam int FRAME_W = T_W + N_W + M_W;
    localparam int T_HI    = FRAME_W - 1;
    localparam int T_LO    = FRAME_W - T_W;
    localparam int N_HI    = T_LO - 1;
    localparam int N_LO    = M_W;
    localparam int PAR_W   = M_W + N_W;

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic [M_W-1:0]     m;
        logic [N_W-1:0]     n;
        logic [T_W-1:0]     t;
    } state_t;

    // Synchronized controls: {mode, sclk, sdata, sload}
    logic [3:0]       ctl_s;
    logic [PAR_W-1:0] par_s;
    logic             mode_s, sclk_s, data_s, sload_s;
    logic [M_W-1:0]   par_m_s;
    logic [N_W-1:0]   par_n_s;
    edge_ev_t         sclk_ev, sload_ev;

    divcfg_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_ctl_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({ser_mode, ser_clk, ser_data, ser_load}),
        .q    (ctl_s)
    );

    divcfg_sync #(.WIDTH(PAR_W), .STAGES(SYNC_STAGES)) u_par_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({par_m, par_n}),
        .q    (par_s)
    );

    assign {mode_s, sclk_s, data_s, sload_s} = ctl_s;
    assign {par_m_s, par_n_s}                = par_s;

    divcfg_edge u_sclk_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (sclk_s),
        .ev   (sclk_ev)
    );

    divcfg_edge u_sload_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (sload_s),
        .ev   (sload_ev)
    );

    state_t state_d, state_q;
    logic   shift_en, commit;

    always_comb begin
        state_d  = state_q;
        shift_en = mode_s & sclk_ev.rise;
        commit   = mode_s & sload_ev.fall;
        if (!mode_s) begin
            // Parallel path has priority: transparent M/N, T cleared.
            state_d.m = par_m_s;
            state_d.n = par_n_s;
            state_d.t = '0;
        end else begin
            if (shift_en) begin
                state_d.sr = {state_q.sr[FRAME_W-2:0], data_s};
            end
            if (commit) begin
                state_d.t = state_q.sr[T_HI:T_LO];
                state_d.n = state_q.sr[N_HI:N_LO];
                state_d.m = state_q.sr[M_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    logic [FRAME_W-1:0] sr_q;
    assign sr_q      = state_q.sr;
    assign m_val     = state_q.m;
    assign n_val     = state_q.n;
    assign t_val     = state_q.t;
    assign shift_out = state_q.sr[FRAME_W-1];

endmodule

// File: rtl/divcfg_port_chk.sv
module divcfg_port_chk #(
    parameter int M_W = 9,
    parameter int N_W = 2,
    parameter int T_W = 3,
    parameter int FRAME_W = M_W + N_W + T_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mode_s,
    input logic               shift_en,
    input logic               commit,
    input logic [M_W-1:0]     par_m_s,
    input logic [N_W-1:0]     par_n_s,
    input logic [FRAME_W-1:0] sr_q,
    input logic [M_W-1:0]     m_val,
    input logic [N_W-1:0]     n_val,
    input logic [T_W-1:0]     t_val,
    input logic               shift_out
);

    assert_t_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_s |=> t_val == '0);

    assert_par_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_s |=> (m_val == $past(par_m_s)) && (n_val == $past(par_n_s)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s && !commit) |=> $stable(m_val) && $stable(n_val) && $stable(t_val));

    assert_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s && commit) |=> {t_val, n_val, m_val} == $past(sr_q));

    assert_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s && shift_en) |=> shift_out == $past(sr_q[FRAME_W-2]));

    assert_no_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_s && shift_en) |=> $stable(sr_q));

endmodule

bind divcfg_port divcfg_port_chk #(
    .M_W(M_W), .N_W(N_W), .T_W(T_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_s   (mode_s),
    .shift_en (shift_en),
    .commit   (commit),
    .par_m_s  (par_m_s),
    .par_n_s  (par_n_s),
    .sr_q     (sr_q),
    .m_val    (m_val),
    .n_val    (n_val),
    .t_val    (t_val),
    .shift_out(shift_out)
);

// File: tb/divcfg_port_bench.sv
module divcfg_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_mode = 1'b0, ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
    logic [8:0] par_m = '0;
    logic [1:0] par_n = '0;
    logic [8:0] m_val;
    logic [1:0] n_val;
    logic [2:0] t_val;
    logic       shift_out;

    always #10 clk = ~clk;  // 50 MHz

    divcfg_port u_divcfg_port (
        .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .ser_clk(ser_clk),
        .ser_data(ser_data), .ser_load(ser_load), .par_m(par_m), .par_n(par_n),
        .m_val(m_val), .n_val(n_val), .t_val(t_val), .shift_out(shift_out)
    );

    typedef struct {
        logic [8:0] m;
        logic [1:0] n;
        logic [2:0] t;
        logic       so;
        string      req;
    } exp_t;

    exp_t  sb_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    // Bench model of the expected state.
    logic [8:0]  e_m = '0;
    logic [1:0]  e_n = '0;
    logic [2:0]  e_t = '0;
    logic [13:0] e_sr = '0;

    task automatic settle();
        repeat (6) @(posedge clk);
    endtask

    task automatic expect_now(input string req);
        exp_t it;
        it.m = e_m; it.n = e_n; it.t = e_t; it.so = e_sr[13]; it.req = req;
        sb_q.push_back(it);
    endtask

    // Monitor: pops expectations and compares at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                checks++;
                if (m_val !== it.m || n_val !== it.n || t_val !== it.t || shift_out !== it.so) begin
                    errors++;
                    $display("FAIL %s: actual m=%h n=%h t=%b so=%b expected m=%h n=%h t=%b so=%b",
                             it.req, m_val, n_val, t_val, shift_out, it.m, it.n, it.t, it.so);
                end
            end
        end
    end

    task automatic set_par(input logic [8:0] m, input logic [1:0] n);
        par_m = m; par_n = n;
        if (!ser_mode) begin e_m = m; e_n = n; end
        settle();
    endtask

    task automatic clk_pulse();
        repeat (4) @(posedge clk);
        ser_clk = 1'b1;
        repeat (4) @(posedge clk);
        ser_clk = 1'b0;
        settle();
    endtask

    task automatic send_bits(input logic [15:0] bits, input int cnt, input string req);
        for (int i = cnt - 1; i >= 0; i--) begin
            ser_data = bits[i];
            clk_pulse();
            if (ser_mode) e_sr = {e_sr[12:0], bits[i]};
            expect_now(req);
        end
    endtask

    task automatic strobe_rise();
        ser_load = 1'b1;
        settle();
    endtask

    task automatic strobe_fall();
        ser_load = 1'b0;
        if (ser_mode) begin
            e_t = e_sr[13:11]; e_n = e_sr[10:9]; e_m = e_sr[8:0];
        end
        settle();
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Driver
    initial begin
        repeat (3) @(posedge clk);
        expect_now("R1 reset held");
        settle();
        rst_n = 1'b1;
        settle();
        expect_now("R1 after reset");

        set_par(9'h1A5, 2'd2);
        expect_now("R2 parallel follow / R3 t zero");
        set_par(9'h0C8, 2'd1);
        expect_now("R2 parallel follow second pattern");

        // Strobe and serial clock while parallel mode: ignored.
        strobe_rise(); strobe_fall();
        expect_now("R8 strobe ignored in parallel mode");
        ser_data = 1'b1;
        clk_pulse();
        expect_now("R10 no shift in parallel mode");

        // Enter serial mode; pins change but values hold.
        ser_mode = 1'b1;
        settle();
        set_par(9'h155, 2'd3);
        expect_now("R9 hold last parallel values");

        // Frame 1: T=110, N=11, M=0x123.
        send_bits({2'b00, 3'b110, 2'b11, 9'h123}, 14, "R4 shift / R7 hold while shifting");
        expect_now("R4 shift_out shows first bit");
        strobe_rise();
        expect_now("R6 rising strobe commits nothing");
        strobe_fall();
        expect_now("R5 R6 commit frame fields");

        // 16 bits: two junk bits then T=001, N=10, M=0x0AB.
        send_bits({2'b11, 3'b001, 2'b10, 9'h0AB}, 16, "R7 hold during long frame");
        strobe_rise(); strobe_fall();
        expect_now("R11 only last 14 bits commit");

        // Back to parallel mode.
        ser_mode = 1'b0;
        e_t = '0; e_m = par_m; e_n = par_n;
        settle();
        expect_now("R3 t cleared in parallel mode");
        set_par(9'h1FF, 2'd0);
        expect_now("R2 parallel all-ones M");
        strobe_rise(); strobe_fall();
        expect_now("R8 strobe ignored after serial use");

        // Serial mode again: register retained through parallel phase.
        ser_mode = 1'b1;
        settle();
        strobe_rise(); strobe_fall();
        expect_now("R10 register retained and committed");

        repeat (4) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule